// File: doc/BRIEF.md
# Packet Ring Writer

This block receives a byte stream of fixed-length transport packets, each tagged with a channel number. For every accepted packet it stores a 4-byte header followed by the 188 payload bytes into a per-channel circular region of memory. Each channel owns four pointers: base, inclusive top, write and read. Because every packet occupies one 192-byte slot, a consumer can walk the region in whole slots. The consumer moves the read pointer forward once it has taken data out. The write pointer is published only after a full slot has landed in memory, so the consumer never sees a slot that is half written.

Software turns each channel on and off and sets up its pointers through a small configuration port. To stop a channel safely, software writes an idle request. That request holds a mask of channels and a request flag. The block raises an interrupt once none of the masked channels is in the middle of storing a packet. Writing zero to the request withdraws it and drops the interrupt. The memory side is a plain one-byte-per-cycle write port.

Top module: `pktRingWriter`

## Requirements
- R1: An accepted packet is stored as a 192-byte slot starting at the channel's write pointer W: the header bytes pktHdr[31:24], [23:16], [15:8] and [7:0] go to W, W+1, W+2 and W+3, and payload byte i goes to W+4+i, for i from 0 to 187.
- R2: The write pointer visible on wrPtr moves by one slot in the cycle after the last payload byte is accepted, and not earlier.
- R3: When W+192 is greater than the inclusive top address, the next write pointer is the base address rather than W+192.
- R4: When a packet starts on an enabled channel whose next write pointer would equal its read pointer, the packet is consumed with no memory write, the write pointer does not move, and that channel's overflow count goes up by one. Equal read and write pointers mean the region is empty.
- R5: A packet that starts on a disabled channel is consumed with no memory write, no pointer change and no overflow count.
- R6: The configuration select codes are 0 for base, 1 for top, 2 for write pointer, 3 for read pointer and 4 for enable (cfgData bit 0). Writes to base, top and write pointer are ignored while the channel is enabled. Read pointer and enable writes are always taken.
- R7: idleData bit NUM_CH is the request flag and bits NUM_CH-1:0 are the channel mask. While the flag is set, idleIrq is high one cycle after no masked channel is storing a packet, and it stays low while a masked channel is storing. Unmasked channels have no effect.
- R8: Writing zero to the idle request drops idleIrq two cycles after the write.
- R9: After reset every write pointer and overflow count is zero, idleIrq is low and memWe is low.
- R10: pktReady is low for the cycle in which a start-of-packet byte is seen and for the four header cycles that follow, and high during payload and drop phases. Bytes that arrive without a start marker while the writer is idle are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pktValid | input | 1 | Input byte valid |
| pktSop | input | 1 | Byte is the first of a packet |
| pktCh | input | CH_W | Channel of the packet, sampled at start |
| pktData | input | 8 | Payload byte |
| pktHdr | input | 32 | Header word, sampled at start |
| pktReady | output | 1 | Byte is accepted at this edge when valid |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCh | input | CH_W | Channel addressed by the configuration write |
| cfgSel | input | 3 | Field select (see R6) |
| cfgData | input | ADDR_W | Configuration value |
| idleWe | input | 1 | Idle request write strobe |
| idleData | input | NUM_CH+1 | Flag in the top bit, channel mask below |
| idleIrq | output | 1 | Masked channels are idle |
| memWe | output | 1 | Memory byte write enable |
| memAddr | output | ADDR_W | Memory byte address |
| memData | output | 8 | Memory byte data |
| wrPtr | output | NUM_CH*ADDR_W | Published write pointers, channel 0 in the low bits |
| ovfCnt | output | NUM_CH*OVF_W | Dropped-packet counts per channel |

## Verification
A corrupted slot offset or header byte order shows up in the stored bytes of the first packet. A wrong wrap limit or a wrong full test is silent until the write pointer reaches the top of the region. At that point the next slot either lands outside the region, or a packet that should be dropped overwrites unread data and the overflow count stays flat. A pointer that is published too early shows up as wrPtr moving before the last payload byte. A stale busy or request state appears as idleIrq rising or falling one cycle away from the expected edge, so the bench checks that signal on exact cycles.

// File: rtl/ringPkg.sv
package ringPkg;
  localparam int PAY_BYTES = 188;
  localparam int HDR_BYTES = 4;
  localparam int STRIDE    = PAY_BYTES + HDR_BYTES;
  localparam int OFF_W     = 8;

  localparam logic [2:0] SEL_BASE = 3'd0;
  localparam logic [2:0] SEL_TOP  = 3'd1;
  localparam logic [2:0] SEL_WP   = 3'd2;
  localparam logic [2:0] SEL_RP   = 3'd3;
  localparam logic [2:0] SEL_EN   = 3'd4;

  typedef struct packed {
    logic             capture;
    logic             hdrWr;
    logic             payWr;
    logic             commit;
    logic             ovfInc;
    logic [1:0]       hdrIdx;
    logic [OFF_W-1:0] payIdx;
  } ringStrobes_t;
endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringPkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic              pktSop,
  input  logic [CH_W-1:0]   pktCh,
  input  logic [NUM_CH-1:0] chEn,
  input  logic [NUM_CH-1:0] chRoom,
  input  logic              idleWe,
  input  logic [NUM_CH:0]   idleData,
  output ringStrobes_t      strobes,
  output logic [CH_W-1:0]   curCh,
  output logic              pktReady,
  output logic [NUM_CH-1:0] busyMask,
  output logic              idleIrq
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_DROP} state_t;

  state_t           state;
  logic [OFF_W-1:0] cnt;
  logic [NUM_CH:0]  idleReq;
  logic             start;
  logic             lastByte;
  logic             hdrLast;

  assign start    = pktValid && pktSop && (state == ST_IDLE);
  assign lastByte = (cnt == OFF_W'(PAY_BYTES - 1));
  assign hdrLast  = (cnt == OFF_W'(HDR_BYTES - 1));

  always_comb begin
    strobes         = '0;
    strobes.capture = start;
    strobes.ovfInc  = start && chEn[pktCh] && !chRoom[pktCh];
    strobes.hdrWr   = (state == ST_HDR);
    strobes.hdrIdx  = cnt[1:0];
    strobes.payWr   = (state == ST_PAY) && pktValid;
    strobes.payIdx  = cnt;
    strobes.commit  = (state == ST_PAY) && pktValid && lastByte;
  end

  assign pktReady = ((state == ST_IDLE) && !pktSop) || (state == ST_PAY) || (state == ST_DROP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      curCh <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          curCh <= pktCh;
          cnt   <= '0;
          if (chEn[pktCh] && chRoom[pktCh]) state <= ST_HDR;
          else                              state <= ST_DROP;
        end
        ST_HDR: begin
          if (hdrLast) begin
            state <= ST_PAY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAY, ST_DROP: if (pktValid) begin
          if (lastByte) state <= ST_IDLE;
          else          cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gBusy
    assign busyMask[g] = ((state == ST_HDR) || (state == ST_PAY)) && (curCh == CH_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleReq <= '0;
      idleIrq <= 1'b0;
    end else begin
      if (idleWe) idleReq <= idleData;
      idleIrq <= idleReq[NUM_CH] && ((idleReq[NUM_CH-1:0] & busyMask) == '0);
    end
  end
endmodule

// File: rtl/ringData.sv
module ringData
  import ringPkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 16,
  parameter int OVF_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ringStrobes_t             strobes,
  input  logic [CH_W-1:0]          curCh,
  input  logic [CH_W-1:0]          pktCh,
  input  logic [7:0]               pktData,
  input  logic [31:0]              pktHdr,
  input  logic                     cfgWe,
  input  logic [CH_W-1:0]          cfgCh,
  input  logic [2:0]               cfgSel,
  input  logic [ADDR_W-1:0]        cfgData,
  output logic [NUM_CH-1:0]        chEn,
  output logic [NUM_CH-1:0]        chRoom,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [7:0]               memData,
  output logic [NUM_CH*ADDR_W-1:0] wrPtr,
  output logic [NUM_CH*OVF_W-1:0]  ovfCnt
);
  logic [31:0]       hdrQ;
  logic [ADDR_W-1:0] wpCur;
  logic [ADDR_W-1:0] off;
  logic [7:0]        hdrByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                hdrQ <= '0;
    else if (strobes.capture) hdrQ <= pktHdr;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [ADDR_W-1:0] baseQ, topQ, wpQ, rpQ, nextWp;
    logic [ADDR_W:0]   sum;
    logic [OVF_W-1:0]  ovfQ;
    logic              enQ;
    logic              sel;

    assign sel    = cfgWe && (cfgCh == CH_W'(g));
    assign sum    = {1'b0, wpQ} + (ADDR_W+1)'(STRIDE);
    assign nextWp = (sum > {1'b0, topQ}) ? baseQ : sum[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        topQ  <= '0;
        wpQ   <= '0;
        rpQ   <= '0;
        enQ   <= 1'b0;
        ovfQ  <= '0;
      end else begin
        if (sel) begin
          case (cfgSel)
            SEL_BASE: if (!enQ) baseQ <= cfgData;
            SEL_TOP:  if (!enQ) topQ  <= cfgData;
            SEL_WP:   if (!enQ) wpQ   <= cfgData;
            SEL_RP:   rpQ <= cfgData;
            SEL_EN:   enQ <= cfgData[0];
            default: ;
          endcase
        end
        if (strobes.commit && (curCh == CH_W'(g))) wpQ <= nextWp;
        if (strobes.ovfInc && (pktCh == CH_W'(g))) ovfQ <= ovfQ + 1'b1;
      end
    end

    assign chEn[g]                       = enQ;
    assign chRoom[g]                     = (nextWp != rpQ);
    assign wrPtr[g*ADDR_W +: ADDR_W]     = wpQ;
    assign ovfCnt[g*OVF_W +: OVF_W]      = ovfQ;
  end

  always_comb begin
    case (strobes.hdrIdx)
      2'd0:    hdrByte = hdrQ[31:24];
      2'd1:    hdrByte = hdrQ[23:16];
      2'd2:    hdrByte = hdrQ[15:8];
      default: hdrByte = hdrQ[7:0];
    endcase
  end

  assign wpCur   = wrPtr[curCh*ADDR_W +: ADDR_W];
  assign off     = strobes.hdrWr ? ADDR_W'(strobes.hdrIdx)
                                 : ADDR_W'(HDR_BYTES) + ADDR_W'(strobes.payIdx);
  assign memWe   = strobes.hdrWr || strobes.payWr;
  assign memAddr = wpCur + off;
  assign memData = strobes.hdrWr ? hdrByte : pktData;
endmodule

// File: rtl/pktRingWriter.sv
module pktRingWriter
  import ringPkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 16,
  parameter int OVF_W  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pktValid,
  input  logic                     pktSop,
  input  logic [CH_W-1:0]          pktCh,
  input  logic [7:0]               pktData,
  input  logic [31:0]              pktHdr,
  output logic                     pktReady,
  input  logic                     cfgWe,
  input  logic [CH_W-1:0]          cfgCh,
  input  logic [2:0]               cfgSel,
  input  logic [ADDR_W-1:0]        cfgData,
  input  logic                     idleWe,
  input  logic [NUM_CH:0]          idleData,
  output logic                     idleIrq,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [7:0]               memData,
  output logic [NUM_CH*ADDR_W-1:0] wrPtr,
  output logic [NUM_CH*OVF_W-1:0]  ovfCnt
);
  ringStrobes_t      strobes;
  logic [CH_W-1:0]   curCh;
  logic [NUM_CH-1:0] chEn, chRoom, busyMask;

  ringCtrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktSop(pktSop), .pktCh(pktCh),
    .chEn(chEn), .chRoom(chRoom), .idleWe(idleWe), .idleData(idleData),
    .strobes(strobes), .curCh(curCh), .pktReady(pktReady),
    .busyMask(busyMask), .idleIrq(idleIrq)
  );

  ringData #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .OVF_W(OVF_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curCh(curCh), .pktCh(pktCh),
    .pktData(pktData), .pktHdr(pktHdr), .cfgWe(cfgWe), .cfgCh(cfgCh),
    .cfgSel(cfgSel), .cfgData(cfgData), .chEn(chEn), .chRoom(chRoom),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .wrPtr(wrPtr), .ovfCnt(ovfCnt)
  );
endmodule

// File: rtl/ringChecker.sv
module ringChecker
  import ringPkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cfgWe,
  input logic                     idleWe,
  input logic [NUM_CH:0]          idleData,
  input logic                     idleIrq,
  input logic                     memWe,
  input logic                     pktValid,
  input logic                     pktReady,
  input logic [NUM_CH*ADDR_W-1:0] wrPtr,
  input logic [NUM_CH-1:0]        busyMask,
  input ringStrobes_t             strobes
);
  // R2: a published pointer only moves after the final payload byte
  assert_wp_moves_on_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgWe) && (wrPtr != $past(wrPtr))) |-> $past(strobes.commit));

  // R8: withdrawing the request drops the interrupt two cycles later
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((idleWe && (idleData == '0)) ##1 !idleWe) |-> ##1 !idleIrq);

  // R7: at most one channel is storing a packet at a time
  assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busyMask));

  // R10: header cycles hold off the input stream
  assert_hdr_stalls_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hdrWr |-> (!pktReady && memWe));

  // R1: each payload write corresponds to an accepted input byte
  assert_payload_accepted_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.payWr |-> (pktValid && pktReady && memWe));

  // R4: a dropped packet produces no memory write in the following cycle
  assert_drop_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ovfInc |=> !memWe);
endmodule

bind pktRingWriter ringChecker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .idleWe(idleWe), .idleData(idleData),
  .idleIrq(idleIrq), .memWe(memWe), .pktValid(pktValid), .pktReady(pktReady),
  .wrPtr(wrPtr), .busyMask(busyMask), .strobes(strobes)
);

// File: tb/tb_pktRingWriter.sv
module tb_pktRingWriter;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 16;
  localparam int OVF_W  = 8;
  localparam int SLOT   = 192;
  localparam int NPAY   = 188;
  localparam int B0     = 0;
  localparam int T0     = 8 * SLOT - 1;
  localparam int B1     = 16'h2000;
  localparam int T1     = 16'h2000 + 8 * SLOT - 1;

  logic clk = 0;
  logic rstN = 0;
  logic pktValid = 0, pktSop = 0;
  logic [0:0] pktCh = 0;
  logic [7:0] pktData = 0;
  logic [31:0] pktHdr = 0;
  logic pktReady;
  logic cfgWe = 0;
  logic [0:0] cfgCh = 0;
  logic [2:0] cfgSel = 0;
  logic [ADDR_W-1:0] cfgData = 0;
  logic idleWe = 0;
  logic [NUM_CH:0] idleData = 0;
  logic idleIrq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;
  logic [NUM_CH*ADDR_W-1:0] wrPtr;
  logic [NUM_CH*OVF_W-1:0] ovfCnt;

  always #2 clk = ~clk;

  pktRingWriter #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OVF_W(OVF_W)) dut (.*);

  logic [7:0] mem [0:65535];
  int memWrites = 0;
  always @(posedge clk) if (memWe) begin
    mem[memAddr] <= memData;
    memWrites <= memWrites + 1;
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] payByte(input int seed, input int i);
    return 8'((seed + i * 7) & 8'hFF);
  endfunction

  function automatic int wpOf(input int ch);
    return int'(wrPtr[ch*ADDR_W +: ADDR_W]);
  endfunction

  function automatic int ovfOf(input int ch);
    return int'(ovfCnt[ch*OVF_W +: OVF_W]);
  endfunction

  task automatic cfgWr(input int ch, input logic [2:0] sel, input int val);
    cfgWe = 1; cfgCh = 1'(ch); cfgSel = sel; cfgData = ADDR_W'(val);
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic idleWr(input logic [NUM_CH:0] val);
    idleWe = 1; idleData = val;
    @(negedge clk);
    idleWe = 0;
  endtask

  task automatic sendPkt(input int ch, input logic [31:0] hdr, input int seed, output int stalls);
    int i;
    bit acc;
    i = 0; stalls = 0;
    pktValid = 1; pktSop = 1; pktCh = 1'(ch); pktHdr = hdr; pktData = payByte(seed, 0);
    while (i < NPAY) begin
      #1 acc = pktReady;
      @(negedge clk);
      if (acc) begin
        i++;
        pktSop = 0;
        pktData = payByte(seed, i);
      end else stalls++;
    end
    pktValid = 0;
  endtask

  task automatic checkSlot(input int start, input logic [31:0] hdr, input int seed, input string tag);
    int errs;
    int firstBad;
    logic [7:0] expB;
    errs = 0; firstBad = -1;
    for (int k = 0; k < SLOT; k++) begin
      expB = (k < 4) ? hdr[8*(3-k) +: 8] : payByte(seed, k - 4);
      if (mem[16'(start + k)] !== expB) begin
        errs++;
        if (firstBad < 0) firstBad = k;
      end
    end
    chk(errs == 0, tag, errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int st, w, expWp;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9: reset state
    chk(wrPtr == '0, "R9 wrPtr", longint'(wrPtr), 0);
    chk(ovfCnt == '0, "R9 ovfCnt", longint'(ovfCnt), 0);
    chk(idleIrq == 0 && memWe == 0, "R9 irq/memWe", {idleIrq, memWe}, 0);

    cfgWr(0, 3'd0, B0); cfgWr(0, 3'd1, T0); cfgWr(0, 3'd2, B0); cfgWr(0, 3'd3, B0);
    cfgWr(1, 3'd0, B1); cfgWr(1, 3'd1, T1); cfgWr(1, 3'd2, B1); cfgWr(1, 3'd3, B1);
    chk(wpOf(1) == B1, "R6 wp write while disabled", wpOf(1), B1);
    cfgWr(0, 3'd4, 1); cfgWr(1, 3'd4, 1);

    // R6: base and wp writes ignored while enabled
    cfgWr(0, 3'd2, 16'h0100);
    cfgWr(0, 3'd0, 16'h4000);
    chk(wpOf(0) == 0, "R6 wp write ignored when enabled", wpOf(0), 0);

    // R1/R2/R10: fill ch0 with seven slots
    for (int p = 0; p < 7; p++) begin
      expWp = p * SLOT;
      sendPkt(0, 32'hA1B2C300 + p, 10 + p, st);
      chk(st == 5, "R10 header stall", st, 5);
      checkSlot(expWp, 32'hA1B2C300 + p, 10 + p, "R1 slot layout");
      chk(wpOf(0) == expWp + SLOT, "R2 wp after packet", wpOf(0), expWp + SLOT);
    end

    // R4: region full (next wp == rp)
    w = memWrites;
    sendPkt(0, 32'hDEADBEEF, 99, st);
    @(negedge clk);
    chk(memWrites == w, "R4 no writes on full", memWrites, w);
    chk(wpOf(0) == 7 * SLOT, "R4 wp held", wpOf(0), 7 * SLOT);
    chk(ovfOf(0) == 1, "R4 overflow count", ovfOf(0), 1);
    chk(st == 1, "R10 drop stall", st, 1);

    // R3: consumer frees space, writer wraps to base (base write above was ignored)
    cfgWr(0, 3'd3, 3 * SLOT);
    sendPkt(0, 32'h11223344, 55, st);
    checkSlot(7 * SLOT, 32'h11223344, 55, "R3 last slot before wrap");
    chk(wpOf(0) == B0, "R3 wrap to base", wpOf(0), B0);
    sendPkt(0, 32'h55667788, 77, st);
    checkSlot(0, 32'h55667788, 77, "R3 slot at base");
    chk(wpOf(0) == SLOT, "R3 wp after wrap", wpOf(0), SLOT);
    chk(ovfOf(0) == 1, "R4 ovf stable", ovfOf(0), 1);

    // Channel 1 traffic, independent of channel 0
    for (int p = 0; p < 2; p++) begin
      sendPkt(1, 32'hC0DE0000 + p, 200 + p, st);
      checkSlot(B1 + p * SLOT, 32'hC0DE0000 + p, 200 + p, "R1 ch1 slot");
      chk(wpOf(1) == B1 + (p + 1) * SLOT, "R2 ch1 wp", wpOf(1), B1 + (p + 1) * SLOT);
    end
    chk(wpOf(0) == SLOT, "R2 ch0 untouched by ch1", wpOf(0), SLOT);

    // R5: disabled channel drops silently
    cfgWr(1, 3'd4, 0);
    w = memWrites;
    sendPkt(1, 32'hFFFF0000, 3, st);
    @(negedge clk);
    chk(memWrites == w, "R5 no writes when disabled", memWrites, w);
    chk(wpOf(1) == B1 + 2 * SLOT, "R5 wp held", wpOf(1), B1 + 2 * SLOT);
    chk(ovfOf(1) == 0, "R5 no overflow count", ovfOf(1), 0);
    cfgWr(1, 3'd2, B1 + 5 * SLOT);
    chk(wpOf(1) == B1 + 5 * SLOT, "R6 wp write when disabled", wpOf(1), B1 + 5 * SLOT);

    // R10: stray bytes without start marker are discarded
    w = memWrites;
    pktValid = 1; pktSop = 0; pktData = 8'h5A;
    #1 chk(pktReady == 1, "R10 stray ready", pktReady, 1);
    repeat (3) @(negedge clk);
    pktValid = 0;
    @(negedge clk);
    chk(memWrites == w && wpOf(0) == SLOT, "R10 stray ignored", memWrites, w);

    // R7/R8: idle handshake
    fork
      sendPkt(0, 32'h0BADF00D, 5, st);
      begin
        repeat (20) @(negedge clk);
        idleWr(3'b110);              // request ch1 only; ch0 is busy
        @(negedge clk);
        chk(idleIrq == 1, "R7 unmasked busy ignored", idleIrq, 1);
        idleWr(3'b000);
        @(negedge clk);
        chk(idleIrq == 0, "R8 clear", idleIrq, 0);
        idleWr(3'b101);              // request ch0 while busy
        repeat (3) @(negedge clk);
        chk(idleIrq == 0, "R7 low while busy", idleIrq, 0);
      end
    join
    chk(idleIrq == 0, "R7 not yet after last byte", idleIrq, 0);
    @(negedge clk);
    chk(idleIrq == 1, "R7 rises when idle", idleIrq, 1);
    idleWr(3'b000);
    chk(idleIrq == 1, "R8 still high one cycle", idleIrq, 1);
    @(negedge clk);
    chk(idleIrq == 0, "R8 low two cycles after", idleIrq, 0);
    checkSlot(SLOT, 32'h0BADF00D, 5, "R1 slot during idle test");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule